// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block gathers 64 interrupt request inputs and turns them into two processor-facing lines: a normal interrupt line and a fast interrupt line. Each source has its own 8-bit control byte. The byte turns the source on, picks level or edge detection, and names the destination the source is routed to. Only the normal and fast destinations drive outputs. The six auxiliary destination codes are kept in the byte and read back, but they reach no output.

Each source has a status bit. Level sources mirror their synchronised input. Edge sources latch the chosen edge and hold it until software writes a one to that bit. For each output, software reads a vector register that returns the number of the winning pending, enabled source routed to that output. Two priority-control registers choose fixed or rotating priority, one per output. All access goes through a simple word-wide register bus with byte enables, and read data comes back one cycle after the request.

Top module: `intr_vector_ctrl`

## Requirements
- R1: After synchronous reset both outputs are 0, every control byte and status bit is 0, both vector registers (0x00 for the normal line, 0x04 for the fast line) read 63, and both priority registers read 0x3F (rotation off, pointer 63).
- R2: The control byte of source n lives at byte address 0x40+n, which is byte lane n%4 of the word at (0x40+n) with the low two address bits cleared. In that byte, bit 3 enables the source and bits 2:0 hold the destination (0 = normal line, 1 = fast line, 2..7 stored only). A write changes only the lanes whose byte enable is set, and the byte reads back exactly as written.
- R3: With control bits 5 and 6 both clear, the source is active-high level. Its status bit follows the input after a two-flop synchroniser, and writing one to that status bit has no effect.
- R4: Control bit 5 latches the status bit on a rising input edge and control bit 6 latches it on a falling edge. A latched bit stays set until it is cleared by a write of one.
- R5: Status word 0x80 holds sources 0..31 and word 0x84 holds sources 32..63, with bit position n%32. A write of one clears a latched bit only when the byte lane holding that bit is enabled. A write of zero changes nothing.
- R6: The normal line is the registered OR of all sources that are pending, enabled and routed to destination 0. The fast line is the same for destination 1. Disabled sources and sources with auxiliary destinations drive neither line.
- R7: Under fixed priority, bits 5:0 of a vector register read return the lowest-numbered pending, enabled source routed to that line, and 63 when there is none. Bits 31:6 read 0. Reading 63 alone is ambiguous, so software checks status bit 63 (bit 31 of 0x84) to tell the cases apart.
- R8: Priority register 0x20 (normal line) and 0x24 (fast line): bit 6 enables rotation and bits 5:0 hold the pointer. A vector read that finds a source loads that source number into the pointer. With rotation on, the search starts at pointer+1 and wraps past 63 to 0. With rotation off, the pointer is ignored.
- R9: Read data appears on the cycle after the request and is 0 when no read is made. An address that is unmapped or not word-aligned reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | 64 | Asynchronous interrupt request inputs, bit n is source n |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| irq_o | output | 1 | Normal interrupt line, registered |
| fiq_o | output | 1 | Fast interrupt line, registered |

## Verification
The hardest case to reach from the ports is the rotating search. The bench has to hold several sources pending together and then read the vector register back to back. Each read must return the next source in circular order, and the sequence must wrap from 63 back to the lowest source. The bench holds three level sources pending, one of them source 63, and reads the vector four times in a row. It also confirms that the same reads under fixed priority keep returning the lowest source. The other hard case is the ambiguous vector value 63. The bench leaves only source 63 pending and checks the vector together with bit 31 of the upper status word.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  // control byte fields
  localparam int CTL_EN_BIT   = 3;
  localparam int CTL_RISE_BIT = 5;
  localparam int CTL_FALL_BIT = 6;
  localparam logic [2:0] DEST_NORMAL = 3'd0;
  localparam logic [2:0] DEST_FAST   = 3'd1;

  // register byte addresses
  localparam int OFS_VEC_BASE  = 'h00;  // +4 per line
  localparam int OFS_PRI_BASE  = 'h20;  // +4 per line
  localparam int OFS_CTL_BASE  = 'h40;
  localparam int OFS_STAT_BASE = 'h80;

  localparam int NUM_LINES = 2;  // 0 = normal, 1 = fast
endpackage

// File: rtl/ivc_src_cell.sv
module ivc_src_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic rise_en,
  input  logic fall_en,
  input  logic clr_i,
  output logic sync_o,
  output logic stat_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic stat_q;
  logic level_mode;
  logic edge_hit;

  assign sync_o     = sync_q[SYNC_STAGES-1];
  assign level_mode = !rise_en && !fall_en;
  assign edge_hit   = (rise_en && sync_o && !prev_q) ||
                      (fall_en && !sync_o && prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], req_i};
      prev_q <= sync_o;
      if (level_mode) stat_q <= sync_o;
      else            stat_q <= edge_hit | (stat_q & ~clr_i);
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/ivc_prio_pick.sv
module ivc_prio_pick #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic             rotate_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  int start;
  int p;

  always_comb begin
    if (!rotate_i || int'(ptr_i) == N - 1) start = 0;
    else start = int'(ptr_i) + 1;
    valid_o = 1'b0;
    idx_o   = IDX_W'(N - 1);
    p       = 0;
    for (int k = 0; k < N; k++) begin
      p = start + k;
      if (p >= N) p = p - N;
      if (!valid_o && req_i[p]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/ivc_ctl_bank.sv
module ivc_ctl_bank #(
  parameter int NUM_SRC = 64,
  parameter int DATA_W  = 32,
  localparam int LANES   = DATA_W / 8,
  localparam int WORDS   = NUM_SRC / LANES,
  localparam int WSEL_W  = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [WSEL_W-1:0]       word_sel,
  input  logic [LANES-1:0]        be,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rd_word,
  output logic [NUM_SRC-1:0][7:0] ctl_o
);
  logic [7:0] mem [NUM_SRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      for (int l = 0; l < LANES; l++)
        if (be[l]) mem[int'(word_sel) * LANES + l] <= wdata[l*8 +: 8];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int l = 0; l < LANES; l++)
      rd_word[l*8 +: 8] = mem[int'(word_sel) * LANES + l];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_out
    assign ctl_o[i] = mem[i];
  end
endmodule

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SRC     = 64,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  irq_src_i,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_o,
  output logic                fiq_o
);
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int LANES      = DATA_W / 8;
  localparam int CTL_WORDS  = NUM_SRC / LANES;
  localparam int CW_W       = $clog2(CTL_WORDS);
  localparam int STAT_WORDS = NUM_SRC / DATA_W;
  localparam int WADDR_W    = ADDR_W - 2;
  localparam int VEC_W0     = OFS_VEC_BASE / 4;
  localparam int PRI_W0     = OFS_PRI_BASE / 4;
  localparam int CTL_W0     = OFS_CTL_BASE / 4;
  localparam int STAT_W0    = OFS_STAT_BASE / 4;
  localparam int ROT_BIT    = IDX_W;

  // ---------------- bus decode ----------------
  logic             do_wr, do_rd, aligned;
  logic [WADDR_W-1:0] waddr;
  logic             hit_ctl;
  logic [CW_W-1:0]  ctl_sel;

  assign do_wr   = bus_sel && bus_wr;
  assign do_rd   = bus_sel && !bus_wr;
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign waddr   = bus_addr[ADDR_W-1:2];
  assign hit_ctl = aligned && (int'(waddr) >= CTL_W0) &&
                   (int'(waddr) < CTL_W0 + CTL_WORDS);
  assign ctl_sel = CW_W'(int'(waddr) - CTL_W0);

  // ---------------- control bytes ----------------
  logic [NUM_SRC-1:0][7:0] ctl;
  logic [DATA_W-1:0]       ctl_rd_word;

  ivc_ctl_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_ctl_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (do_wr && hit_ctl),
    .word_sel (ctl_sel),
    .be       (bus_be),
    .wdata    (bus_wdata),
    .rd_word  (ctl_rd_word),
    .ctl_o    (ctl)
  );

  // ---------------- status clear decode ----------------
  logic [NUM_SRC-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    for (int j = 0; j < STAT_WORDS; j++) begin
      if (do_wr && aligned && int'(waddr) == STAT_W0 + j) begin
        for (int b = 0; b < DATA_W; b++)
          clr_vec[j*DATA_W + b] = bus_wdata[b] & bus_be[b/8];
      end
    end
  end

  // ---------------- per-source cells ----------------
  logic [NUM_SRC-1:0] stat_vec;
  logic [NUM_SRC-1:0] sync_vec;
  logic [NUM_SRC-1:0] lvl_mask;
  logic [NUM_LINES-1:0][NUM_SRC-1:0] line_req;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic enabled;
    assign enabled     = ctl[i][CTL_EN_BIT];
    assign lvl_mask[i] = !ctl[i][CTL_RISE_BIT] && !ctl[i][CTL_FALL_BIT];
    assign line_req[0][i] = stat_vec[i] && enabled && (ctl[i][2:0] == DEST_NORMAL);
    assign line_req[1][i] = stat_vec[i] && enabled && (ctl[i][2:0] == DEST_FAST);

    ivc_src_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .req_i   (irq_src_i[i]),
      .rise_en (ctl[i][CTL_RISE_BIT]),
      .fall_en (ctl[i][CTL_FALL_BIT]),
      .clr_i   (clr_vec[i]),
      .sync_o  (sync_vec[i]),
      .stat_o  (stat_vec[i])
    );
  end

  // ---------------- priority per output line ----------------
  logic [NUM_LINES-1:0]            rot_q;
  logic [NUM_LINES-1:0][IDX_W-1:0] ptr_q;
  logic [NUM_LINES-1:0]            pick_valid;
  logic [NUM_LINES-1:0][IDX_W-1:0] pick_idx;
  logic [NUM_LINES-1:0]            line_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic vec_rd, pri_wr;
    assign vec_rd = do_rd && aligned && int'(waddr) == VEC_W0 + g;
    assign pri_wr = do_wr && aligned && int'(waddr) == PRI_W0 + g && bus_be[0];

    ivc_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
      .req_i    (line_req[g]),
      .rotate_i (rot_q[g]),
      .ptr_i    (ptr_q[g]),
      .valid_o  (pick_valid[g]),
      .idx_o    (pick_idx[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        rot_q[g]  <= 1'b0;
        ptr_q[g]  <= IDX_W'(NUM_SRC - 1);
        line_q[g] <= 1'b0;
      end else begin
        line_q[g] <= |line_req[g];
        if (pri_wr) begin
          rot_q[g] <= bus_wdata[ROT_BIT];
          ptr_q[g] <= bus_wdata[IDX_W-1:0];
        end else if (vec_rd && pick_valid[g]) begin
          ptr_q[g] <= pick_idx[g];
        end
      end
    end
  end

  assign irq_o = line_q[0];
  assign fiq_o = line_q[1];

  // ---------------- read mux ----------------
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      for (int g = 0; g < NUM_LINES; g++) begin
        if (int'(waddr) == VEC_W0 + g)
          rd_mux = DATA_W'(pick_idx[g]);
        if (int'(waddr) == PRI_W0 + g)
          rd_mux = DATA_W'({rot_q[g], ptr_q[g]});
      end
      for (int j = 0; j < STAT_WORDS; j++)
        if (int'(waddr) == STAT_W0 + j)
          rd_mux = stat_vec[j*DATA_W +: DATA_W];
      if (hit_ctl) rd_mux = ctl_rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (do_rd) bus_rdata <= rd_mux;
    else            bus_rdata <= '0;
  end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] sync_vec,
  input logic [NUM_SRC-1:0] lvl_mask,
  input logic [IDX_W-1:0]   irq_ptr
);
  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    int v;
    v = int'(a);
    if (a[1:0] != 2'b00) return 1'b0;
    return (v == OFS_VEC_BASE) || (v == OFS_VEC_BASE + 4) ||
           (v == OFS_PRI_BASE) || (v == OFS_PRI_BASE + 4) ||
           (v >= OFS_CTL_BASE && v < OFS_CTL_BASE + NUM_SRC) ||
           (v >= OFS_STAT_BASE && v < OFS_STAT_BASE + NUM_SRC / 8);
  endfunction

  // R1: outputs and read data are quiet in the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq_o && !fiq_o && bus_rdata == '0));

  // R3: level-mode status equals the synchronised input one cycle later
  assert_level_track_R3: assert property (@(posedge clk) disable iff (rst)
    (stat_q & $past(lvl_mask)) == ($past(sync_vec) & $past(lvl_mask)));

  // R6: no pending status means both lines low next cycle
  assert_lines_idle_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(stat_q) == '0) |-> (!irq_o && !fiq_o));

  // R7: vector read carries only the source number field
  assert_vec_field_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && int'(bus_addr) == OFS_VEC_BASE) |=>
      (bus_rdata[DATA_W-1:IDX_W] == '0));

  // R8: the normal-line pointer moves only on a vector read or priority write
  assert_ptr_cause_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(irq_ptr) |-> ($past(bus_sel) &&
      (int'($past(bus_addr)) == OFS_VEC_BASE || int'($past(bus_addr)) == OFS_PRI_BASE)));

  // R9: unmapped or misaligned reads return zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && !is_mapped(bus_addr)) |=> (bus_rdata == '0));
endmodule

bind intr_vector_ctrl ivc_checker #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_ivc_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .stat_q    (stat_vec),
  .sync_vec  (sync_vec),
  .lvl_mask  (lvl_mask),
  .irq_ptr   (ptr_q[0])
);

// File: tb/test_intr_vector_ctrl.sv
`timescale 1ns/1ps
module test_intr_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  logic arm = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  intr_vector_ctrl i_intr_vector_ctrl (
    .clk(clk), .rst(rst), .irq_src_i(src),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // monitor: compare read data against the scoreboard queue
  always @(posedge clk) arm <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (arm) begin
      item_t it;
      total++;
      if (sb_q.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected read data %h", "R9", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic chk(input logic got, input logic e, input string tag);
    total++;
    if (got !== e) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(irq_o, 1'b0, "R1 irq_o");
    chk(fiq_o, 1'b0, "R1 fiq_o");
    rd(8'h00, 32'h3F, "R1 normal vector");
    rd(8'h04, 32'h3F, "R1 fast vector");
    rd(8'h20, 32'h3F, "R1 normal prio");
    rd(8'h24, 32'h3F, "R1 fast prio");
    rd(8'h40, 32'h0, "R1 ctl word");
    rd(8'h80, 32'h0, "R1 status low");

    // R2 byte lanes
    wr(8'h44, 4'b0010, 32'hAABB09CC);
    rd(8'h44, 32'h00000900, "R2 lane1 only");
    wr(8'h7C, 4'b1000, 32'h5A000000);
    rd(8'h7C, 32'h5A000000, "R2 byte 63 aux dest");
    wr(8'h7C, 4'b1000, 32'h0);

    // R3 level source 2
    wr(8'h40, 4'b0100, 32'h00080000);
    src[2] = 1'b1; idle(6);
    chk(irq_o, 1'b1, "R3 level raises irq");
    rd(8'h80, 32'h4, "R3 level status");
    rd(8'h00, 32'h2, "R7 vector src2");
    wr(8'h80, 4'hF, 32'h4);
    rd(8'h80, 32'h4, "R3 level ignores clear");
    src[2] = 1'b0; idle(6);
    chk(irq_o, 1'b0, "R3 level drops irq");
    rd(8'h80, 32'h0, "R3 level status low");
    rd(8'h00, 32'h3F, "R7 none pending");

    // R4 rising edge source 40
    wr(8'h68, 4'b0001, 32'h28);
    src[40] = 1'b1; idle(3); src[40] = 1'b0; idle(6);
    rd(8'h84, 32'h100, "R4 rising latched");
    chk(irq_o, 1'b1, "R4 edge irq");
    rd(8'h00, 32'd40, "R7 vector src40");
    wr(8'h84, 4'hF, 32'h0);
    rd(8'h84, 32'h100, "R5 zero write keeps");
    wr(8'h84, 4'hF, 32'h100); idle(4);
    rd(8'h84, 32'h0, "R5 one clears");
    chk(irq_o, 1'b0, "R4 irq after clear");
    // R4 falling edge source 41
    wr(8'h68, 4'b0010, 32'h4800);
    src[41] = 1'b1; idle(6);
    rd(8'h84, 32'h0, "R4 falling ignores rise");
    src[41] = 1'b0; idle(6);
    rd(8'h84, 32'h200, "R4 falling latched");
    chk(irq_o, 1'b1, "R4 falling irq");
    wr(8'h84, 4'b0001, 32'h200);
    rd(8'h84, 32'h200, "R5 lane disabled keeps");
    wr(8'h84, 4'b0010, 32'h200);
    rd(8'h84, 32'h0, "R5 lane enabled clears");
    wr(8'h68, 4'b0011, 32'h0);

    // R6 fast line, aux dest, disabled
    src[5] = 1'b1; idle(6);
    chk(fiq_o, 1'b1, "R6 fast line high");
    chk(irq_o, 1'b0, "R6 normal line low");
    rd(8'h04, 32'h5, "R7 fast vector");
    rd(8'h00, 32'h3F, "R7 normal vector none");
    wr(8'h44, 4'b0100, 32'h000A0000);
    src[5] = 1'b0; src[6] = 1'b1; src[7] = 1'b1; idle(6);
    chk(fiq_o, 1'b0, "R6 aux dest no fast");
    chk(irq_o, 1'b0, "R6 aux/disabled no normal");
    rd(8'h80, 32'hC0, "R6 status raw");
    src[6] = 1'b0; src[7] = 1'b0; idle(6);
    rd(8'h80, 32'h0, "R3 status cleared");

    // R7 fixed priority among 3, 10, 63
    wr(8'h40, 4'b1000, 32'h08000000);
    wr(8'h48, 4'b0100, 32'h00080000);
    wr(8'h7C, 4'b1000, 32'h08000000);
    src[3] = 1'b1; src[10] = 1'b1; src[63] = 1'b1; idle(6);
    rd(8'h00, 32'd3, "R7 lowest wins");
    rd(8'h00, 32'd3, "R7 fixed repeat");
    src[3] = 1'b0; idle(6);
    rd(8'h00, 32'd10, "R7 next lowest");
    src[10] = 1'b0; idle(6);
    rd(8'h00, 32'd63, "R7 src63 vector");
    rd(8'h84, 32'h80000000, "R7 status bit63");
    chk(irq_o, 1'b1, "R6 src63 irq");
    src[3] = 1'b1; src[10] = 1'b1; idle(6);

    // R8 rotating priority
    rd(8'h24, 32'h05, "R8 fast pointer after read");
    wr(8'h20, 4'b0001, 32'h7F);
    rd(8'h00, 32'd3, "R8 rotate first");
    rd(8'h00, 32'd10, "R8 rotate second");
    rd(8'h00, 32'd63, "R8 rotate third");
    rd(8'h00, 32'd3, "R8 rotate wrap");
    rd(8'h20, 32'h43, "R8 pointer value");
    wr(8'h20, 4'b0001, 32'h05);
    rd(8'h00, 32'd3, "R8 fixed ignores pointer");

    // R9 unmapped
    rd(8'h10, 32'h0, "R9 unmapped read");
    wr(8'h10, 4'hF, 32'hFFFFFFFF);
    rd(8'h10, 32'h0, "R9 unmapped write ignored");
    rd(8'h41, 32'h0, "R9 misaligned");
    rd(8'h88, 32'h0, "R9 past status");
    rd(8'hFC, 32'h0, "R9 top address");
    idle(3);
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R9: got %0d pending reads expected 0", sb_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule